// File: doc/BRIEF.md
# Serial EEPROM Read Engine

This block is the target side of a two-wire serial bus for a byte-addressed memory of 8192 bytes. It watches oversampled clock and data lines, finds Start and Stop conditions, and matches the device select byte against a fixed 7-bit code. It answers three kinds of read: the current address read, the random read, and sequential reads that follow either of them. A random read first sends a write-mode select and two address bytes with no Stop, then a repeated Start. The only drive onto the data line is a pull-down enable. Storage sits behind a synchronous read port, and the nonvolatile write path lives elsewhere.

An internal 13-bit address counter keeps its value from one transaction to the next. It steps by one for every byte placed on the line and wraps from the top address to zero. After each byte the engine samples the master's acknowledge in the ninth clock. If the master does not acknowledge, the engine drops into standby until the next Start.

The memory port is a fixed-latency request interface, not a valid/ready stream. A one-cycle request pulse carries the address, and the byte must be present on the next cycle. There is no back-pressure: the engine fetches each byte a full bit time before it needs it, so a memory that keeps the one-cycle latency never stalls it.

Top module: `ee_read_slave`

## Requirements
- R1: After reset the pull-down is released and no memory request is issued. A Start seen at any point restarts select decoding, even with no Stop before it. A Stop returns the engine to standby with the line released.
- R2: When a select byte's upper seven bits differ from the device code (default 7'h50), no acknowledge is given. The engine then ignores all bytes until the next Start and leaves the address counter unchanged.
- R3: For a random read, the write-mode select (bit 0 = 0), the high address byte and the low address byte are each acknowledged. A repeated Start follows, then a read-mode select (bit 0 = 1), which is acknowledged. The first byte sent is the one at the loaded address.
- R4: A current address read (Start, then a read-mode select) is acknowledged and sends the byte at the counter. The counter value is kept from earlier transactions.
- R5: The address counter goes up by one for each byte sent, and acknowledged bytes carry on from consecutive addresses.
- R6: A sequential read that passes address 8191 continues at address 0.
- R7: A byte the master does not acknowledge in the ninth clock ends the transfer. The engine does not pull the line low again until the next Start. The byte that was not acknowledged still counts as sent.
- R8: The pull-down enable changes only while the clock line is low.
- R9: Of the high address byte, only the low 5 bits are kept. The upper 3 bits are ignored.
- R10: Data is sent most significant bit first. Each memory request is a single-cycle pulse, and the byte is taken on the following cycle.
- R11: A data byte that follows the two address bytes of a write-mode select is not acknowledged, and the counter keeps the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Drive the data line low when 1 |
| mem_rd_en | output | 1 | Single-cycle memory read request |
| mem_addr | output | 13 | Read address, equal to the address counter |
| mem_rdata | input | 8 | Byte returned one cycle after the request |

## Verification
A wrong address counter shows in the first data byte of the next read, and every later byte of that read shows it again. A counter that skips or stalls shows on the second byte of a sequential read. A broken bit counter or shift register corrupts or shifts the byte that is returned, or misplaces the acknowledge within the same byte frame. A state machine that fails to reach standby shows as a low level on the data line in the very next clock after a missing acknowledge or a bad select, because the line can then no longer read as all ones.

// File: rtl/ee_rd_pkg.sv
package ee_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,  // standby, waiting for a Start
    ST_DEV,   // shifting in the select byte
    ST_AHI,   // shifting in the high address byte
    ST_ALO,   // shifting in the low address byte
    ST_ACK,   // driving our acknowledge slot
    ST_TX,    // shifting a data byte out
    ST_MACK,  // waiting for the master acknowledge
    ST_MOK    // master acknowledged, next byte loads at clock fall
  } rd_state_e;
endpackage

// File: rtl/ee_line_mon.sv
module ee_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC_STAGES:0] scl_pipe, sda_pipe;
  logic scl_s, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_i};
    end
  end

  assign scl_s    = scl_pipe[SYNC_STAGES-1];
  assign scl_p    = scl_pipe[SYNC_STAGES];
  assign sda_s    = sda_pipe[SYNC_STAGES-1];
  assign sda_p    = sda_pipe[SYNC_STAGES];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  // data edges while the clock stays high mark bus conditions
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/ee_addr_ctr.sv
module ee_addr_ctr #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (inc)  count <= count + 1'b1;  // natural wrap to zero
  end
endmodule

// File: rtl/ee_read_slave.sv
module ee_read_slave
  import ee_rd_pkg::*;
#(
  parameter int         MEM_BYTES   = 8192,
  parameter logic [6:0] DEV_CODE    = 7'h50,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata
);
  localparam int HI_BITS = AW - 8;

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  rd_state_e state, ret_state;
  logic [3:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh, rd_q;
  logic [HI_BITS-1:0] hi_q;
  logic rd_pend;
  logic byte_done, dev_hit, ctr_load, ctr_inc, rd_fire;
  logic [AW-1:0] cur_addr;

  ee_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign byte_done = scl_fall && (bit_cnt == 4'd8);
  assign dev_hit   = (rx_sh[7:1] == DEV_CODE);
  assign ctr_load  = (state == ST_ALO) && byte_done;
  assign ctr_inc   = scl_fall && (((state == ST_ACK) && (ret_state == ST_TX)) ||
                                  (state == ST_MOK));
  assign rd_fire   = ((state == ST_DEV) && byte_done && dev_hit && rx_sh[0]) ||
                     ((state == ST_TX) && byte_done);

  ee_addr_ctr #(.AW(AW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val({hi_q, rx_sh}),
    .inc(ctr_inc), .count(cur_addr)
  );

  assign mem_addr = cur_addr;

  // read port: one-cycle request, data captured the cycle after
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rd_en <= 1'b0;
      rd_pend   <= 1'b0;
      rd_q      <= '0;
    end else begin
      mem_rd_en <= rd_fire;
      rd_pend   <= mem_rd_en;
      if (rd_pend) rd_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ret_state <= ST_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      hi_q      <= '0;
      sda_oe    <= 1'b0;
    end else if (stop_ev) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (start_ev) begin
      state   <= ST_DEV;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_AHI, ST_ALO: begin
          if (scl_rise) begin
            rx_sh   <= {rx_sh[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            bit_cnt <= '0;
            if (state == ST_DEV) begin
              if (dev_hit) begin
                sda_oe    <= 1'b1;
                state     <= ST_ACK;
                ret_state <= rx_sh[0] ? ST_TX : ST_AHI;
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_AHI) begin
              hi_q      <= rx_sh[HI_BITS-1:0];
              sda_oe    <= 1'b1;
              state     <= ST_ACK;
              ret_state <= ST_ALO;
            end else begin
              sda_oe    <= 1'b1;
              state     <= ST_ACK;
              ret_state <= ST_IDLE;  // write data belongs to another block
            end
          end
        end
        ST_ACK, ST_MOK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if ((state == ST_MOK) || (ret_state == ST_TX)) begin
              state  <= ST_TX;
              tx_sh  <= {rd_q[6:0], 1'b0};
              sda_oe <= ~rd_q[7];
            end else begin
              state  <= ret_state;
              sda_oe <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              sda_oe <= 1'b0;
              state  <= ST_MACK;
            end else begin
              sda_oe <= ~tx_sh[7];
              tx_sh  <= {tx_sh[6:0], 1'b0};
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) state <= sda_s ? ST_IDLE : ST_MOK;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ee_read_slave_chk.sv
module ee_read_slave_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_oe,
  input logic          mem_rd_en,
  input logic          start_ev,
  input logic          stop_ev,
  input logic          ctr_inc,
  input logic [AW-1:0] count
);
  assert_oe_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  assert_start_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe);

  assert_ctr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_inc |=> (count == AW'($past(count) + 1'b1)));

  assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
endmodule

bind ee_read_slave ee_read_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .mem_rd_en(mem_rd_en), .start_ev(start_ev), .stop_ev(stop_ev),
  .ctr_inc(ctr_inc), .count(cur_addr)
);

// File: tb/ee_read_slave_tb.sv
module ee_read_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int MEM_BYTES  = 8192;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, mem_rd_en;
  logic [12:0] mem_addr;
  logic [7:0] mem_rdata = '0;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  int exp_addr = 0;
  int oe_bad = 0;
  logic prev_oe = 1'b0, prev_scl = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  ee_read_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] mem_val(input int a);
    return 8'((a * 37) ^ (a >> 8) ^ 8'h5A);
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem_val(int'(mem_addr));

  // R8: the line must not move while the clock is high
  always @(negedge clk) begin
    if (rst_n && scl_m && prev_scl && (sda_oe !== prev_oe)) oe_bad++;
    prev_oe  = sda_oe;
    prev_scl = scl_m;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    sda_m = 1'b0; tick(HALF);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic do_stop();
    scl_m = 1'b0; tick(2);
    sda_m = 1'b0; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    sda_m = 1'b1; tick(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(HALF);
      scl_m = 1'b1; tick(HALF);
      scl_m = 1'b0; tick(2);
    end
    sda_m = 1'b1; tick(HALF);
    scl_m = 1'b1; tick(HALF/2);
    acked = !sda_line; tick(HALF/2);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    for (int i = 7; i >= 0; i--) begin
      tick(HALF);
      scl_m = 1'b1; tick(HALF/2);
      b[i] = sda_line; tick(HALF/2);
      scl_m = 1'b0; tick(2);
    end
    sda_m = give_ack ? 1'b0 : 1'b1; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    scl_m = 1'b0; tick(2);
    sda_m = 1'b1;
  endtask

  // rnd=1: random read at a (with dummy write); rnd=0: current address read
  task automatic rd_txn(input logic rnd, input logic [15:0] a, input int n, input string req);
    logic ack;
    logic [7:0] d;
    do_start();
    if (rnd) begin
      send_byte({DEV, 1'b0}, ack); check(req, ack, 1);
      send_byte(a[15:8], ack);     check(req, ack, 1);
      send_byte(a[7:0], ack);      check(req, ack, 1);
      exp_addr = int'(a) % MEM_BYTES;  // R9 upper bits dropped
      do_start();
    end
    send_byte({DEV, 1'b1}, ack); check(req, ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(d, k != n - 1);
      check((k == 0) ? req : "R5", d, mem_val(exp_addr));
      exp_addr = (exp_addr + 1) % MEM_BYTES;
    end
    do_stop();
  endtask

  task automatic bad_select(input logic [6:0] code, input string req);
    logic ack;
    do_start();
    send_byte({code, 1'b1}, ack); check(req, ack, 0);
    send_byte({DEV, 1'b1}, ack);  check(req, ack, 0);  // no Start: still ignored
    do_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    int op, n;
    logic [15:0] a;
    void'($urandom(32'd2024));
    tick(5);
    check("R1", sda_oe, 0);
    check("R10", mem_rd_en, 0);
    rst_n = 1'b1;
    tick(5);
    check("R1", sda_oe, 0);

    rd_txn(1'b1, 16'h0123, 1, "R3");
    rd_txn(1'b0, 16'h0000, 2, "R4");
    rd_txn(1'b1, 16'hE005, 2, "R9");
    rd_txn(1'b1, 16'h1FFE, 4, "R6");
    rd_txn(1'b1, 16'h00A7, 1, "R10");

    // R2: mismatch, then counter unchanged
    bad_select(DEV ^ 7'h01, "R2");
    rd_txn(1'b0, 16'h0000, 1, "R2");

    // R1: Start after a rejected select, no Stop in between
    do_start();
    send_byte({DEV ^ 7'h40, 1'b1}, ack); check("R2", ack, 0);
    do_start();
    send_byte({DEV, 1'b1}, ack); check("R1", ack, 1);
    recv_byte(d, 1'b0); check("R1", d, mem_val(exp_addr));
    exp_addr = (exp_addr + 1) % MEM_BYTES;
    do_stop();

    // R7: after a missing acknowledge the line stays released
    do_start();
    send_byte({DEV, 1'b1}, ack); check("R7", ack, 1);
    recv_byte(d, 1'b0); check("R7", d, mem_val(exp_addr));
    exp_addr = (exp_addr + 1) % MEM_BYTES;
    recv_byte(d, 1'b0); check("R7", d, 8'hFF);
    do_stop();
    rd_txn(1'b0, 16'h0000, 1, "R7");

    // R11: write data after the address is not acknowledged
    do_start();
    send_byte({DEV, 1'b0}, ack); check("R11", ack, 1);
    send_byte(8'h03, ack);       check("R11", ack, 1);
    send_byte(8'h3C, ack);       check("R11", ack, 1);
    send_byte(8'h99, ack);       check("R11", ack, 0);
    do_stop();
    exp_addr = 16'h033C;
    rd_txn(1'b0, 16'h0000, 1, "R11");

    for (int it = 0; it < 30; it++) begin
      op = int'($urandom_range(0, 3));
      n  = int'($urandom_range(1, 4));
      a  = 16'($urandom);
      case (op)
        0: rd_txn(1'b0, a, n, "R4");
        1: rd_txn(1'b1, a, n, "R3");
        2: begin
          bad_select(DEV ^ 7'($urandom_range(1, 127)), "R2");
          rd_txn(1'b0, a, 1, "R2");
        end
        default: begin
          a[12:0] = 13'(MEM_BYTES - 1 - int'($urandom_range(0, 2)));
          rd_txn(1'b1, a, 4, "R6");
        end
      endcase
    end

    check("R8", oe_bad, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule